// File: doc/BRIEF.md
# Addressed Multiprocessor Serial Receiver

This block receives asynchronous serial frames and carries one extra bit in each frame. That bit marks the frame as a station address (ID) or as payload. A divider input sets the oversampling tick rate. The block synchronises the line and detects start bits by oversampling. It shifts in the frame and updates a small set of register-style flags: data ready, overrun, framing error and ID-wait.

Software uses the ID-wait bit to look for its own address. After software arms ID-wait, the block ignores every payload frame until an address frame arrives. The block stores that address frame, raises data-ready and disarms ID-wait by itself. Software compares the address. If it does not match, software arms ID-wait again. If it matches, software lets the following payload frames through. While either error flag is set, the block loads no frames until software clears both flags. The synchronised line level stays readable at all times, so software can tell a break from an ordinary framing fault.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is a low start bit, DATA_W payload bits with the least significant bit first, one address-marker bit, and a high stop bit. The line is sampled on a tick that occurs once every `baud_div`+1 clocks, with OVS ticks per bit. The default is 16.
- R2: A payload frame received while ID-wait is 0 and no flag is set goes to `rx_data`, sets `rx_ready` to 1 and sets `rx_is_id` to the marker bit. A pulse on `ready_clr` returns `rx_ready` to 0.
- R3: A frame that completes while `rx_ready` is 1 sets `overrun`. `rx_data` keeps the earlier byte, and the block discards the new frame.
- R4: A pulse on `idwait_set` sets `id_wait` to 1. While `id_wait` is 1, a frame with marker bit 0 changes neither `rx_data` nor `rx_ready`.
- R5: A frame with marker bit 1 (an address frame) is stored and sets `rx_ready` and `rx_is_id` to 1. If `id_wait` was 1, the hardware clears it to 0, and later payload frames are then accepted.
- R6: A stop bit sampled low sets `frame_err` and stores nothing.
- R7: While `overrun` or `frame_err` is 1, the block loads no frame. Once `overrun_clr` or `frame_err_clr` has cleared both flags, reception resumes.
- R8: `line_level` follows `rx_serial` after SYNC_STAGES clocks. It therefore reads 0 while the line is held in a break.
- R9: While `rx_enable` is 0, the block receives nothing. Dropping `rx_enable` in the middle of a frame abandons that frame.
- R10: A low pulse that has ended before the mid-bit point of the start bit is rejected as noise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Tick period minus one, in clocks |
| rx_serial | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Receive enable |
| idwait_set | input | 1 | Pulse: arm the wait for an address frame |
| ready_clr | input | 1 | Pulse: clear rx_ready |
| overrun_clr | input | 1 | Pulse: clear overrun |
| frame_err_clr | input | 1 | Pulse: clear frame_err |
| rx_data | output | DATA_W | Last stored byte |
| rx_is_id | output | 1 | Marker bit of the stored frame |
| rx_ready | output | 1 | Received byte waiting |
| id_wait | output | 1 | Waiting for an address frame |
| overrun | output | 1 | Frame lost while rx_ready was set |
| frame_err | output | 1 | Stop bit sampled low |
| line_level | output | 1 | Synchronised serial line level |

## Verification
Payload bytes 0xA5, 0x3C, 0x00 and 0xFF exercise bit order and the edge values of every bit position. A payload frame sent after ID-wait is armed, followed by an address frame and then another payload frame, separates discarding from storing and checks the automatic disarm. A pair of frames sent with no read between them, and a frame with a low stop bit followed by a held-low line, exercise each error flag. A frame sent while each flag is set shows that reception is blocked and then resumes. A short low glitch, and a frame cut off when enable drops, must both leave `rx_ready` at 0.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_phase_e;
endpackage

// File: rtl/mpuart_tick.sv
module mpuart_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (tick)  cnt_q <= div;
      else            cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/mpuart_sampler.sv
module mpuart_sampler
   import mpuart_pkg::*;
#(
   parameter int OVS     = 16,
   parameter int FRAME_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic               rx,
   output logic               done,
   output logic [FRAME_W-1:0] frame,
   output logic               stop_ok
);
   localparam int CW  = $clog2(OVS);
   localparam int BW  = $clog2(FRAME_W + 1);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);
   localparam logic [BW-1:0] TOPB = BW'(FRAME_W - 1);

   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 4");
   end

   rx_phase_e          phase_q;
   logic [CW-1:0]      cnt_q;
   logic [BW-1:0]      bit_q;
   logic [FRAME_W-1:0] sh_q;
   logic               done_q, stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= RX_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         done_q  <= 1'b0;
         stop_q  <= 1'b1;
      end else begin
         done_q <= 1'b0;
         if (!run) begin
            phase_q <= RX_IDLE;
            cnt_q   <= '0;
         end else if (tick) begin
            unique case (phase_q)
               RX_IDLE: if (!rx) begin
                  phase_q <= RX_START;
                  cnt_q   <= '0;
               end
               RX_START: if (cnt_q == MID) begin
                  phase_q <= rx ? RX_IDLE : RX_BITS;
                  cnt_q   <= '0;
                  bit_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
               RX_BITS: if (cnt_q == LAST) begin
                  cnt_q <= '0;
                  sh_q  <= {rx, sh_q[FRAME_W-1:1]};
                  if (bit_q == TOPB) phase_q <= RX_STOP;
                  else               bit_q   <= bit_q + 1'b1;
               end else cnt_q <= cnt_q + 1'b1;
               RX_STOP: if (cnt_q == LAST) begin
                  done_q  <= 1'b1;
                  stop_q  <= rx;
                  phase_q <= RX_IDLE;
                  cnt_q   <= '0;
               end else cnt_q <= cnt_q + 1'b1;
               default: phase_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign done    = done_q;
   assign frame   = sh_q;
   assign stop_ok = stop_q;

   a_r9_idle_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> phase_q == RX_IDLE);
   a_r1_done_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/mpuart_flags.sv
module mpuart_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W:0]   frame,
   input  logic              stop_ok,
   input  logic              id_set,
   input  logic              rdy_clr,
   input  logic              ovr_clr,
   input  logic              frm_clr,
   output logic [DATA_W-1:0] data,
   output logic              id_bit,
   output logic              full,
   output logic              ovr,
   output logic              frm,
   output logic              idw
);
   logic mpb;
   assign mpb = frame[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data   <= '0;
         id_bit <= 1'b0;
         full   <= 1'b0;
         ovr    <= 1'b0;
         frm    <= 1'b0;
         idw    <= 1'b0;
      end else begin
         if (rdy_clr) full <= 1'b0;
         if (ovr_clr) ovr  <= 1'b0;
         if (frm_clr) frm  <= 1'b0;
         if (id_set)  idw  <= 1'b1;
         if (done) begin
            if (!stop_ok)          frm <= 1'b1;
            else if (idw && !mpb)  ;
            else if (full)         ovr <= 1'b1;
            else begin
               data   <= frame[DATA_W-1:0];
               id_bit <= mpb;
               full   <= 1'b1;
               if (mpb) idw <= 1'b0;
            end
         end
      end
   end

   a_r4_payload_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (done && stop_ok && !mpb && idw && !rdy_clr) |=> ($stable(full) && $stable(data)));
   a_r5_id_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (done && stop_ok && mpb && idw && !full && !id_set) |=> (!idw && full));
   a_r3_old_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done && stop_ok && full && !rdy_clr && !ovr_clr && (mpb || !idw)) |=> (ovr && $stable(data)));
   a_r6_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !stop_ok && !frm_clr) |=> (frm && $stable(data)));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              rx_serial,
   input  logic              rx_enable,
   input  logic              idwait_set,
   input  logic              ready_clr,
   input  logic              overrun_clr,
   input  logic              frame_err_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_is_id,
   output logic              rx_ready,
   output logic              id_wait,
   output logic              overrun,
   output logic              frame_err,
   output logic              line_level
);
   localparam int FRAME_W = DATA_W + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 5) begin : g_bad_width
      $error("DATA_W must be at least 5");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_serial};
   end
   assign line_level = sync_q[SYNC_STAGES-1];

   logic run, tick, done, stop_ok;
   logic [FRAME_W-1:0] frame;

   assign run = rx_enable && !overrun && !frame_err;

   mpuart_tick #(.DIV_W(DIV_W)) tick_i (
      .clk(clk), .rst_n(rst_n), .run(run), .div(baud_div), .tick(tick));

   mpuart_sampler #(.OVS(OVS), .FRAME_W(FRAME_W)) samp_i (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .rx(line_level),
      .done(done), .frame(frame), .stop_ok(stop_ok));

   mpuart_flags #(.DATA_W(DATA_W)) flags_i (
      .clk(clk), .rst_n(rst_n), .done(done), .frame(frame), .stop_ok(stop_ok),
      .id_set(idwait_set), .rdy_clr(ready_clr), .ovr_clr(overrun_clr),
      .frm_clr(frame_err_clr), .data(rx_data), .id_bit(rx_is_id),
      .full(rx_ready), .ovr(overrun), .frm(frame_err), .idw(id_wait));

   a_r7_no_load_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun || frame_err) |-> !done);
   a_r9_no_load_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_enable && !ready_clr) |=> !$rose(rx_ready));
endmodule

// File: tb/mp_uart_rx_tb_top.sv
module mp_uart_rx_tb_top;
   localparam int DIV     = 1;
   localparam int BIT_CLK = 16 * (DIV + 1);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] baud_div = 8'(DIV);
   logic       rx_serial = 1'b1;
   logic       rx_enable = 1'b0;
   logic       idwait_set = 1'b0, ready_clr = 1'b0, overrun_clr = 1'b0, frame_err_clr = 1'b0;
   logic [7:0] rx_data;
   logic       rx_is_id, rx_ready, id_wait, overrun, frame_err, line_level;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [8:0] exp_q[$];

   always #2.5 clk = ~clk;

   mp_uart_rx dut_i (
      .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx_serial(rx_serial),
      .rx_enable(rx_enable), .idwait_set(idwait_set), .ready_clr(ready_clr),
      .overrun_clr(overrun_clr), .frame_err_clr(frame_err_clr),
      .rx_data(rx_data), .rx_is_id(rx_is_id), .rx_ready(rx_ready),
      .id_wait(id_wait), .overrun(overrun), .frame_err(frame_err),
      .line_level(line_level));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_bit(input logic b);
      rx_serial = b;
      wait_clk(BIT_CLK);
   endtask

   // R1: start, 8 data LSB first, marker, stop
   task automatic send(input logic [7:0] d, input logic mp, input logic stop, input bit expect_store);
      if (expect_store) exp_q.push_back({mp, d});
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(d[i]);
      drive_bit(mp);
      drive_bit(stop);
      rx_serial = 1'b1;
      wait_clk(8);
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      wait_clk(1);
      sig = 1'b0;
      wait_clk(1);
   endtask

   // scoreboard monitor
   logic prev_ready = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_ready && !prev_ready) begin
            if (exp_q.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R2/R4: unexpected store actual %0h expected none", {rx_is_id, rx_data});
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk("R2/R5 stored frame", {23'd0, rx_is_id, rx_data}, {23'd0, e});
            end
         end
         prev_ready <= rx_ready;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      chk("R2 reset ready", rx_ready, 0);
      chk("R3 reset overrun", overrun, 0);
      chk("R6 reset frame_err", frame_err, 0);
      chk("R4 reset id_wait", id_wait, 0);
      chk("R8 reset line", line_level, 1);
      rx_enable = 1'b1;
      wait_clk(4);

      // R1 R2: several payload patterns
      send(8'hA5, 0, 1, 1); chk("R2 ready set", rx_ready, 1); pulse(ready_clr);
      chk("R2 ready cleared", rx_ready, 0);
      send(8'h3C, 0, 1, 1); pulse(ready_clr);
      send(8'h00, 0, 1, 1); pulse(ready_clr);
      send(8'hFF, 0, 1, 1); pulse(ready_clr);

      // R3 overrun, R7 blocked then resumed
      send(8'h5A, 0, 1, 1);
      send(8'hC3, 0, 1, 0);
      chk("R3 overrun set", overrun, 1);
      chk("R3 old data kept", rx_data, 8'h5A);
      send(8'h77, 0, 1, 0);
      chk("R7 blocked data", rx_data, 8'h5A);
      chk("R7 no frame error", frame_err, 0);
      pulse(overrun_clr); pulse(ready_clr);
      chk("R7 overrun cleared", overrun, 0);
      send(8'h81, 0, 1, 1);
      chk("R7 resumed", rx_ready, 1);
      pulse(ready_clr);

      // R4 R5 ID wait
      pulse(idwait_set);
      chk("R4 armed", id_wait, 1);
      send(8'h11, 0, 1, 0);
      chk("R4 payload ignored ready", rx_ready, 0);
      chk("R4 payload ignored data", rx_data, 8'h81);
      chk("R4 still armed", id_wait, 1);
      send(8'h42, 1, 1, 1);
      chk("R5 id disarmed", id_wait, 0);
      chk("R5 id flag", rx_is_id, 1);
      pulse(ready_clr);
      send(8'h99, 0, 1, 1);
      chk("R5 payload after id", rx_data, 8'h99);
      pulse(ready_clr);

      // R6 framing error, R8 break readback
      send(8'h66, 0, 0, 0);
      rx_serial = 1'b0;
      wait_clk(40);
      chk("R6 frame_err", frame_err, 1);
      chk("R6 nothing stored", rx_ready, 0);
      chk("R8 break level", line_level, 0);
      rx_serial = 1'b1;
      wait_clk(4);
      chk("R8 idle level", line_level, 1);
      send(8'h24, 0, 1, 0);
      chk("R7 blocked by frame_err", rx_ready, 0);
      pulse(frame_err_clr);
      chk("R7 frame_err cleared", frame_err, 0);
      send(8'h18, 0, 1, 1);
      chk("R7 resumed after frame_err", rx_ready, 1);
      pulse(ready_clr);

      // R10 glitch rejection
      rx_serial = 1'b0; wait_clk(4); rx_serial = 1'b1;
      wait_clk(BIT_CLK * 12);
      chk("R10 glitch rejected", rx_ready, 0);
      chk("R10 no error", frame_err, 0);

      // R9 enable drop mid-frame
      drive_bit(1'b0);
      for (int i = 0; i < 4; i++) drive_bit(1'b1);
      rx_enable = 1'b0;
      for (int i = 0; i < 6; i++) drive_bit(1'b0);
      rx_serial = 1'b1;
      wait_clk(BIT_CLK);
      rx_enable = 1'b1;
      wait_clk(BIT_CLK * 12);
      chk("R9 aborted frame", rx_ready, 0);
      chk("R9 no error", frame_err, 0);
      send(8'hE7, 0, 1, 1);
      chk("R9 receives after enable", rx_ready, 1);
      pulse(ready_clr);

      chk("R2 scoreboard drained", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule